// File: doc/BRIEF.md
# Predicated Lane-wise Vector Left Shifter

This block is a pipelined vector execution unit. Each operation carries three vectors of `VLEN` bits: values to shift, per-lane shift counts, and the prior contents of the destination. It also carries a per-lane enable mask and a two-bit element-size code. The vector is split into lanes of 8, 16, 32 or 64 bits, chosen per operation. Every enabled lane shifts its value left by the count held in the same lane of the count vector. Every disabled lane returns its prior destination value untouched. Signed and unsigned integers behave the same, because a left shift does not depend on signedness.

Operations enter through a valid/ready handshake and leave through a second valid/ready handshake after a fixed pipeline depth of seven stages. When the consumer withholds ready, the whole pipeline freezes. The unit therefore accepts one operation per cycle exactly when the consumer is ready. Reset empties the pipeline by clearing its valid bits only.

Top module: `vec_lshift_pred`

## Requirements
- R1: In an enabled lane, the result is the lane value shifted left by that lane's count. Zeros fill from the least significant bit, and bits moved past the top of the lane are lost. Each lane uses only its own count.
- R2: The count is the whole lane-wide field of the count vector, read as unsigned. Any count equal to or above the lane width, including counts with the top bit set, gives an all-zero lane.
- R3: Lane i occupies bits [i*w +: w], where w is the lane width, and is enabled by `lane_en[i]`. A lane whose enable bit is 0 outputs the same bits of `dst_old` unchanged.
- R4: `elem_sz` selects the lane width: 2'b00 for 8 bits, 2'b01 for 16, 2'b10 for 32 and 2'b11 for 64. The lane count is VLEN/w. Enable bits at or above VLEN/w have no effect.
- R5: An operation taken on a rising edge where `in_valid` and `in_ready` are both high leaves on the seventh later rising edge where `out_ready` is high. With no stalls, that is exactly 7 cycles after acceptance.
- R6: `in_ready` equals `out_ready`, so one operation can be accepted every cycle the consumer is ready, even while a result leaves on the same edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable on the next cycle.
- R8: Reset clears every pipeline valid bit. `out_valid` stays low after reset until a newly accepted operation has passed all seven stages.
- R9: Every accepted operation leaves exactly once, in acceptance order. At most seven operations are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_val | input | VLEN | Lane values to shift |
| src_cnt | input | VLEN | Per-lane unsigned shift counts |
| dst_old | input | VLEN | Prior destination, kept in disabled lanes |
| lane_en | input | VLEN/8 | Per-lane enable mask, bit i for lane i |
| elem_sz | input | 2 | Lane width code |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VLEN | Merged result vector |

## Verification
The two functions that share a cycle are acceptance of a new operation and delivery of an older result on the same edge. A stall can also freeze an offered operation and a waiting result together. The bench keeps `in_valid` asserted almost every cycle while `out_ready` toggles at random, so that acceptance, delivery and stalls mix freely. A reference model and an in-order scoreboard judge every delivered vector. The bench also counts the ready edges between acceptance and delivery and expects exactly seven.

// File: rtl/vec_lshift_pred.sv
`timescale 1ns/1ps
module vec_lshift_pred #(
  parameter int VLEN  = 256,
  parameter int DEPTH = 7,
  localparam int MW = VLEN / 8,
  localparam int NR = DEPTH - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] src_val,
  input  logic [VLEN-1:0] src_cnt,
  input  logic [VLEN-1:0] dst_old,
  input  logic [MW-1:0]   lane_en,
  input  logic [1:0]      elem_sz,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_data
);

  logic                 v1;
  logic [VLEN-1:0]      a1, c1, o1;
  logic [MW-1:0]        m1;
  logic [1:0]           sz1;
  logic [3:0][VLEN-1:0] merged;
  logic [NR-1:0]        pv;
  logic [VLEN-1:0]      pd [NR];
  logic                 adv;

  assign adv       = out_ready;
  assign in_ready  = out_ready;
  assign out_valid = pv[NR-1];
  assign out_data  = pd[NR-1];

  for (genvar g = 0; g < 4; g++) begin : g_size
    localparam int W  = 8 << g;
    localparam int LW = 3 + g;
    localparam int N  = VLEN / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0] av, cv, ov;
      assign av = a1[i*W +: W];
      assign cv = c1[i*W +: W];
      assign ov = o1[i*W +: W];
      assign merged[g][i*W +: W] = !m1[i]         ? ov :
                                   (|(cv >> LW))  ? '0 :
                                   (av << cv[LW-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      pv <= '0;
    end else if (adv) begin
      v1    <= in_valid;
      pv[0] <= v1;
      for (int k = 1; k < NR; k++) pv[k] <= pv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      a1    <= src_val;
      c1    <= src_cnt;
      o1    <= dst_old;
      m1    <= lane_en;
      sz1   <= elem_sz;
      pd[0] <= merged[sz1];
      for (int k = 1; k < NR; k++) pd[k] <= pd[k-1];
    end
  end

endmodule

module vec_lshift_pred_chk #(
  parameter int VLEN  = 256,
  parameter int DEPTH = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] out_data
);

  localparam int CW = $clog2(DEPTH + 2) + 1;
  logic [CW-1:0] infl;

  always_ff @(posedge clk) begin
    if (rst) infl <= '0;
    else infl <= infl + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
  end

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  p_rise_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(out_ready));

  p_inflight_bound_r9: assert property (@(posedge clk) disable iff (rst)
    infl <= CW'(DEPTH));

  p_output_has_source_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (infl != '0));

endmodule

bind vec_lshift_pred vec_lshift_pred_chk #(.VLEN(VLEN), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

// File: tb/vec_lshift_pred_bench.sv
`timescale 1ns/1ps
module vec_lshift_pred_bench;
  localparam int VLEN = 256;
  localparam int MW   = VLEN / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [VLEN-1:0] src_val = '0, src_cnt = '0, dst_old = '0, out_data;
  logic [MW-1:0] lane_en = '0;
  logic [1:0] elem_sz = '0;

  always #2 clk = ~clk;

  vec_lshift_pred u_vec_lshift_pred (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_val(src_val), .src_cnt(src_cnt), .dst_old(dst_old),
    .lane_en(lane_en), .elem_sz(elem_sz), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  int checks = 0, failures = 0;
  bit done = 0;
  int stall_pct = 0;
  logic [VLEN-1:0] exp_q[$];
  string tag_q[$];
  int rc_q[$];
  int redges = 0;
  bit accepted;
  bit stall_pend = 0;
  logic [VLEN-1:0] stall_data;

  function automatic logic [VLEN-1:0] ref_shift(input logic [VLEN-1:0] a, c, o,
                                                input logic [MW-1:0] m, input logic [1:0] sz);
    int w, n;
    logic [VLEN-1:0] r;
    logic [63:0] av, cv, res;
    w = 8 << int'(sz);
    n = VLEN / w;
    r = o;
    for (int i = 0; i < n; i++) begin
      av = '0; cv = '0;
      for (int j = 0; j < w; j++) begin
        av[j] = a[i*w+j];
        cv[j] = c[i*w+j];
      end
      if (m[i]) begin
        res = (cv >= 64'(w)) ? 64'd0 : (av << cv);
        for (int j = 0; j < w; j++) r[i*w+j] = res[j];
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string msg, input logic [VLEN-1:0] got, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", msg, got, exp);
    end
  endtask

  task automatic cycle(input string tag);
    out_ready = ($urandom % 100) >= stall_pct;
    #1;
    accepted = 0;
    if (rst) begin
      exp_q.delete(); tag_q.delete(); rc_q.delete();
      stall_pend = 0;
    end else begin
      check(in_ready == out_ready, "R6 in_ready tracks out_ready", VLEN'(in_ready), VLEN'(out_ready));
      if (stall_pend) begin
        check(out_valid == 1'b1, "R7 valid held in stall", VLEN'(out_valid), VLEN'(1));
        check(out_data == stall_data, "R7 data held in stall", out_data, stall_data);
      end
      stall_pend = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected output", out_data, '0);
        else begin
          check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
          check(redges - rc_q[0] == 7, "R5 latency in ready edges", VLEN'(redges - rc_q[0]), VLEN'(7));
          void'(exp_q.pop_front()); void'(tag_q.pop_front()); void'(rc_q.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        accepted = 1;
        exp_q.push_back(ref_shift(src_val, src_cnt, dst_old, lane_en, elem_sz));
        tag_q.push_back(tag);
        rc_q.push_back(redges);
      end
      if (out_ready) redges++;
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [VLEN-1:0] a, c, o, input logic [MW-1:0] m,
                      input logic [1:0] sz, input string tag);
    src_val = a; src_cnt = c; dst_old = o; lane_en = m; elem_sz = sz;
    in_valid = 1'b1;
    do cycle(tag); while (!accepted);
    in_valid = 1'b0;
  endtask

  function automatic logic [VLEN-1:0] rvec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VLEN-1:0] rcnt(input logic [1:0] sz);
    int w;
    logic [VLEN-1:0] v;
    logic [63:0] cv;
    w = 8 << int'(sz);
    v = rvec();
    for (int i = 0; i < VLEN / w; i++) begin
      cv = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % (w + 2));
      for (int j = 0; j < w; j++) v[i*w+j] = cv[j];
    end
    return v;
  endfunction

  function automatic logic [VLEN-1:0] fill(input logic [63:0] val, input logic [1:0] sz);
    int w;
    logic [VLEN-1:0] v;
    w = 8 << int'(sz);
    v = '0;
    for (int i = 0; i < VLEN / w; i++)
      for (int j = 0; j < w; j++) v[i*w+j] = val[j];
    return v;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset state out_valid", VLEN'(out_valid), '0);
    rst = 1'b0;
    cycle("idle");
    check(out_valid == 1'b0, "R8 idle after reset", VLEN'(out_valid), '0);

    send(fill(64'h81, 0), fill(64'd1, 0), rvec(), '1, 2'b00, "R1 8b overflow drop");
    send(fill(64'h01, 0), fill(64'd7, 0), rvec(), '1, 2'b00, "R1 8b max shift");
    send(fill(64'hA5, 0), fill(64'd0, 0), rvec(), '1, 2'b00, "R1 zero shift");
    send(fill(64'hFF, 0), fill(64'd8, 0), rvec(), '1, 2'b00, "R2 count equals width");
    send(fill(64'hFF, 0), fill(64'h80, 0), rvec(), '1, 2'b00, "R2 count top bit set");
    send(fill(64'h1234, 1), fill(64'h0100, 1), rvec(), '1, 2'b01, "R2 16b high count byte");
    send(fill(64'd1, 3), fill(64'd63, 3), rvec(), '1, 2'b11, "R1 64b shift 63");
    send(fill(64'd1, 3), fill(64'd64, 3), rvec(), '1, 2'b11, "R2 64b shift 64");
    send(rvec(), rcnt(2), rvec(), '0, 2'b10, "R3 all lanes disabled");
    send(rvec(), rcnt(2), rvec(), 32'h0000_00A5, 2'b10, "R3 alternating enables");
    send(rvec(), rcnt(3), rvec(), 32'hFFFF_FFF0, 2'b11, "R4 upper enables ignored 64b");
    send(rvec(), rcnt(1), rvec(), 32'hFFFF_0000, 2'b01, "R4 upper enables ignored 16b");
    repeat (10) cycle("drain");

    for (int n = 0; n < 300; n++) begin
      logic [1:0] sz;
      sz = 2'($urandom);
      send(rvec(), rcnt(sz), rvec(), MW'({$urandom}), sz, "R1 R3 R4 random back-to-back");
    end
    stall_pct = 40;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz;
      sz = 2'($urandom);
      send(rvec(), rcnt(sz), rvec(), MW'({$urandom}), sz, "R6 R7 random with stalls");
      if ($urandom % 5 == 0) cycle("gap");
    end
    stall_pct = 0;
    repeat (12) cycle("drain");
    check(exp_q.size() == 0, "R9 all results delivered", VLEN'(exp_q.size()), '0);

    stall_pct = 30;
    for (int n = 0; n < 5; n++) send(rvec(), rcnt(0), rvec(), '1, 2'b00, "pre-reset");
    stall_pct = 0;
    rst = 1'b1;
    cycle("reset");
    cycle("reset");
    rst = 1'b0;
    for (int n = 0; n < 9; n++) begin
      cycle("post-reset");
      check(out_valid == 1'b0, "R8 no output after mid-run reset", VLEN'(out_valid), '0);
    end
    send(fill(64'h3, 2), fill(64'd30, 2), rvec(), '1, 2'b10, "R5 R8 first op after reset");
    repeat (10) cycle("drain");
    check(exp_q.size() == 0, "R9 queue empty at end", VLEN'(exp_q.size()), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule